// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block lets a clocked host read and write one external 8K x 8 asynchronous static RAM. The host presents an address, a direction flag and (for writes) a byte with a request level. The block latches them when it is idle, runs the access on the RAM pins and returns a one-cycle acknowledge. For reads, the returned byte is valid in that same cycle.

The RAM side has two chip selects of opposite polarity, an active-low output enable and an active-low write enable. The shared data bus is split into an outgoing byte, a drive enable and an incoming byte, so a pad ring or a bench can resolve it. Timing is given as nanosecond parameters plus the clock period. Each one is rounded up to whole cycles: the address access time, the write pulse width, the time for the RAM outputs to float after the write strobe falls, and the data-valid-before-strobe-end time. Writes are strobe-controlled, and the output enable stays high throughout them. Between accesses the RAM is left in standby.

Top module: `sram_ctrl`

## Requirements
- R1: After reset and whenever no access is in progress, the RAM is deselected (`mem_sel_n`=1, `mem_sel`=0), `mem_oe_n`=1, `mem_we_n`=1 and `mem_dq_oe`=0.
- R2: During an access the two selects are always opposite: `mem_sel_n` low exactly when `mem_sel` is high.
- R3: A read keeps the RAM selected with `mem_oe_n`=0 and `mem_we_n`=1 for RD = ceil(T_ACC_NS/CLK_NS) cycles. It captures `mem_dq_i` on the last of them and raises `host_ack` with that byte on `host_rdata`, RD+1 cycles after the cycle in which the request was first presented.
- R4: A write holds `mem_we_n` low for WZ+DRV cycles. Here WZ = ceil(T_WZ_NS/CLK_NS), DW = ceil(T_DW_NS/CLK_NS), WP = ceil(T_WP_NS/CLK_NS) and DRV = max(DW, WP-WZ, 1). The byte is driven only in the last DRV of those cycles, never in the first WZ. `host_ack` rises WZ+DRV+2 cycles after the request was first presented.
- R5: `mem_oe_n` stays high in every cycle where `mem_we_n` is low.
- R6: `mem_dq_oe` is low in the cycle before any cycle in which `mem_oe_n` falls, including a read that directly follows a write.
- R7: `mem_addr` does not change while the RAM stays selected, and read data is captured before the address can change.
- R8: Host address, data and direction are taken only in the accept cycle. Changes to them during an access do not affect that access.
- R9: The write ends by raising `mem_we_n` and releasing both selects on the same edge. The write byte stays driven for one further cycle.
- R10: `host_ack` is a single-cycle pulse, given once per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Access request level, taken when idle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 13 | Word address |
| host_wdata | input | 8 | Byte to write |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Byte read, valid with `host_ack` |
| mem_addr | output | 13 | RAM address pins |
| mem_dq_o | output | 8 | Byte driven onto the RAM data bus |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_i | input | 8 | Byte seen on the RAM data bus |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low RAM output enable |
| mem_we_n | output | 1 | Active-low RAM write strobe |

## Verification
The bench's RAM model returns a poison byte until the output enable has been held for the full access count. A shortened read therefore shows up as a data mismatch rather than passing silently. The write data bytes 00, FF, AA, 55 and pseudo-random pairs are chosen to expose stuck or swapped data bits. The addresses 0 and 8191 expose truncated address bits. Write-then-read on the same address separates correct turnaround from bus contention, which the model flags in any cycle where both sides drive. Changing the host inputs in the middle of an access shows whether the request is latched or still tracked.

// File: rtl/sram_ctrl_pkg.sv
// Shared types and helpers for the static RAM access sequencer.
// Assumes timing parameters are positive nanosecond values.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_READ     = 3'd1,
        ST_WR_HIZ   = 3'd2,
        ST_WR_DRIVE = 3'd3,
        ST_WR_HOLD  = 3'd4
    } seq_state_e;

    // Round a nanosecond figure up to whole clock cycles, at least one.
    function automatic int ns_to_cycles(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_timer.sv
// Down-counter that times one phase of an access.
// Assumes the loaded value is the phase length minus one; done is high
// in the last cycle of the phase.
module sram_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    // Load a new phase length or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (load)            cnt_q <= load_val;
        else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_seq.sv
// Access state machine: accepts a request when idle, steps through the
// read or write phases using the phase timer, and raises the acknowledge.
// Assumes all cycle counts are at least one.
module sram_seq
    import sram_ctrl_pkg::*;
#(
    parameter int RD_CYC  = 3,
    parameter int WZ_CYC  = 2,
    parameter int DRV_CYC = 2,
    parameter int CNT_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_wr,
    input  logic             timer_done,
    output logic             timer_load,
    output logic [CNT_W-1:0] timer_val,
    output logic             accept,
    output logic             capture,
    output logic             ack,
    output seq_state_e       state
);
    seq_state_e nxt;
    logic       ack_set;

    // Next-state and timer-load decisions for each phase.
    always_comb begin
        nxt        = state;
        timer_load = 1'b0;
        timer_val  = '0;
        accept     = 1'b0;
        capture    = 1'b0;
        ack_set    = 1'b0;
        case (state)
            ST_IDLE: begin
                if (req) begin
                    accept     = 1'b1;
                    timer_load = 1'b1;
                    if (req_wr) begin
                        nxt       = ST_WR_HIZ;
                        timer_val = CNT_W'(WZ_CYC - 1);
                    end else begin
                        nxt       = ST_READ;
                        timer_val = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            ST_READ: begin
                if (timer_done) begin
                    capture = 1'b1;
                    ack_set = 1'b1;
                    nxt     = ST_IDLE;
                end
            end
            ST_WR_HIZ: begin
                if (timer_done) begin
                    timer_load = 1'b1;
                    timer_val  = CNT_W'(DRV_CYC - 1);
                    nxt        = ST_WR_DRIVE;
                end
            end
            ST_WR_DRIVE: begin
                if (timer_done) nxt = ST_WR_HOLD;
            end
            ST_WR_HOLD: begin
                ack_set = 1'b1;
                nxt     = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State and acknowledge registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ack   <= 1'b0;
        end else begin
            state <= nxt;
            ack   <= ack_set;
        end
    end

    // R10: acknowledge lasts one cycle only.
    p_ack_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
endmodule

// File: rtl/sram_ctrl.sv
// Top of the static RAM access sequencer. Latches the host request,
// drives the RAM pins as a registered decode of the sequencer state and
// captures read data. Assumes one RAM, split data bus at the pins.
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 13,
    parameter int DATA_W   = 8,
    parameter int CLK_NS   = 5,
    parameter int T_ACC_NS = 15,
    parameter int T_WP_NS  = 12,
    parameter int T_WZ_NS  = 7,
    parameter int T_DW_NS  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ack,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_oe_n,
    output logic              mem_we_n
);
    localparam int RD_CYC  = ns_to_cycles(T_ACC_NS, CLK_NS);
    localparam int WP_CYC  = ns_to_cycles(T_WP_NS, CLK_NS);
    localparam int WZ_CYC  = ns_to_cycles(T_WZ_NS, CLK_NS);
    localparam int DW_CYC  = ns_to_cycles(T_DW_NS, CLK_NS);
    localparam int DRV_CYC = imax(imax(DW_CYC, WP_CYC - WZ_CYC), 1);
    localparam int MAX_CYC = imax(imax(RD_CYC, WZ_CYC), DRV_CYC);
    localparam int CNT_W   = imax($clog2(MAX_CYC + 1), 1);

    seq_state_e        state;
    logic              timer_load, timer_done, accept, capture;
    logic [CNT_W-1:0]  timer_val;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;

    sram_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (timer_load),
        .load_val (timer_val),
        .done     (timer_done)
    );

    sram_seq #(
        .RD_CYC  (RD_CYC),
        .WZ_CYC  (WZ_CYC),
        .DRV_CYC (DRV_CYC),
        .CNT_W   (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (host_req),
        .req_wr     (host_wr),
        .timer_done (timer_done),
        .timer_load (timer_load),
        .timer_val  (timer_val),
        .accept     (accept),
        .capture    (capture),
        .ack        (host_ack),
        .state      (state)
    );

    // Latch the host address and byte at accept; hold them through the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= host_addr;
            wdata_q <= host_wdata;
        end
    end

    // Capture the RAM byte on the final read cycle, before the address can move.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_q <= '0;
        else if (capture) rdata_q <= mem_dq_i;
    end

    // Pin decode from the state register.
    always_comb begin
        mem_sel_n = 1'b1;
        mem_sel   = 1'b0;
        mem_oe_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_dq_oe = 1'b0;
        case (state)
            ST_READ: begin
                mem_sel_n = 1'b0;
                mem_sel   = 1'b1;
                mem_oe_n  = 1'b0;
            end
            ST_WR_HIZ: begin
                mem_sel_n = 1'b0;
                mem_sel   = 1'b1;
                mem_we_n  = 1'b0;
            end
            ST_WR_DRIVE: begin
                mem_sel_n = 1'b0;
                mem_sel   = 1'b1;
                mem_we_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            ST_WR_HOLD: mem_dq_oe = 1'b1;
            default: ;
        endcase
    end

    assign mem_addr   = addr_q;
    assign mem_dq_o   = wdata_q;
    assign host_rdata = rdata_q;

    // R6: driver is off in the cycle before the output enable falls.
    p_release_before_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> !$past(mem_dq_oe));
    // R7: address held while the RAM stays selected.
    p_addr_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_sel_n && $past(!mem_sel_n)) |-> $stable(mem_addr));
    // R9: end of strobe releases selects, data still driven.
    p_hold_after_we_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_dq_oe && mem_sel_n && !mem_sel));
    // R4: driver turns on only after the strobe has been low a cycle.
    p_drive_after_float_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (!mem_we_n && $past(!mem_we_n)));
    // R5: output enable stays high while writing.
    p_oe_high_in_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);
    // R1: acknowledge comes with the RAM back in standby.
    p_ack_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |-> (mem_sel_n && mem_oe_n && mem_we_n && !mem_dq_oe));
endmodule

// File: tb/test_sram_ctrl.sv
`timescale 1ns/1ps
module test_sram_ctrl;
    localparam int CLK_NS = 5, T_ACC = 15, T_WP = 12, T_WZ = 7, T_DW = 8;
    localparam int RD  = (T_ACC + CLK_NS - 1) / CLK_NS;
    localparam int WP  = (T_WP + CLK_NS - 1) / CLK_NS;
    localparam int WZ  = (T_WZ + CLK_NS - 1) / CLK_NS;
    localparam int DW  = (T_DW + CLK_NS - 1) / CLK_NS;
    localparam int DRV = (DW > WP - WZ) ? DW : ((WP - WZ) > 1 ? WP - WZ : 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic host_req = 1'b0, host_wr = 1'b0, host_ack;
    logic [12:0] host_addr = '0, mem_addr;
    logic [7:0] host_wdata = '0, host_rdata, mem_dq_o, mem_dq_i;
    logic mem_dq_oe, mem_sel_n, mem_sel, mem_oe_n, mem_we_n;

    int n_chk = 0, n_err = 0;
    logic [7:0] ram [int];
    logic [7:0] expv [int];

    always #2.5 clk = ~clk;

    sram_ctrl i_sram_ctrl (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
        .host_rdata(host_rdata), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i), .mem_sel_n(mem_sel_n),
        .mem_sel(mem_sel), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
    );

    // ---- behavioural RAM model with pin-timing checks ----
    logic sel, model_drive;
    int rd_age = 0;
    assign sel = !mem_sel_n && mem_sel;
    assign model_drive = sel && !mem_oe_n && mem_we_n;

    always @(posedge clk) rd_age <= model_drive ? rd_age + 1 : 0;

    always_comb begin
        if (!model_drive)          mem_dq_i = 8'h00;
        else if (rd_age < RD - 1)  mem_dq_i = 8'hEE;
        else if (ram.exists(int'(mem_addr))) mem_dq_i = ram[int'(mem_addr)];
        else                       mem_dq_i = 8'h00;
    end

    int e_pol = 0, e_cont = 0, e_addr = 0, e_oe_wr = 0, e_wz = 0;
    int e_wp = 0, e_dw = 0, e_hold = 0, e_turn = 0;
    int we_cnt = 0, dw_cnt = 0;
    logic p_sel = 1'b0, p_we_n = 1'b1, p_oe_n = 1'b1, p_dq_oe = 1'b0;
    logic [12:0] p_addr = '0;
    logic [7:0] last_dq = '0;

    always @(negedge clk) if (rst_n) begin
        if (mem_sel_n == mem_sel) e_pol++;                 // R2
        if (mem_dq_oe && model_drive) e_cont++;            // R6
        if (sel && p_sel && mem_addr != p_addr) e_addr++;  // R7
        if (p_oe_n && !mem_oe_n && p_dq_oe) e_turn++;      // R6
        if (!mem_we_n) begin
            we_cnt++;
            if (!mem_oe_n) e_oe_wr++;                      // R5
            if (mem_dq_oe && we_cnt <= WZ) e_wz++;         // R4
            if (mem_dq_oe) begin dw_cnt++; last_dq = mem_dq_o; end
        end
        if (!p_we_n && mem_we_n) begin
            if (we_cnt < WP) e_wp++;                       // R4
            if (dw_cnt < DW) e_dw++;                       // R4
            if (!mem_dq_oe || sel) e_hold++;               // R9
            ram[int'(p_addr)] = last_dq;
            we_cnt = 0; dw_cnt = 0;
        end
        p_sel = sel; p_we_n = mem_we_n; p_oe_n = mem_oe_n;
        p_dq_oe = mem_dq_oe; p_addr = mem_addr;
    end

    // ---- checking helpers ----
    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [12:0] a);
        return expv.exists(int'(a)) ? expv[int'(a)] : 8'h00;
    endfunction

    task automatic access(input logic w, input logic [12:0] a, input logic [7:0] d,
                          output int lat, output logic [7:0] rd, output int acks);
        host_req = 1'b1; host_wr = w; host_addr = a; host_wdata = d;
        lat = 0; acks = 0;
        do begin @(negedge clk); lat++; end while (!host_ack && lat < 50);
        rd = host_rdata; host_req = 1'b0; acks = host_ack ? 1 : 0;
        @(negedge clk);
        if (host_ack) acks++;
    endtask

    task automatic do_write(input logic [12:0] a, input logic [7:0] d);
        int lat, acks; logic [7:0] rd;
        access(1'b1, a, d, lat, rd, acks);
        expv[int'(a)] = d;
        chk(lat == WZ + DRV + 2, "R4 write latency", lat, WZ + DRV + 2);
        chk(acks == 1, "R10 one ack per write", acks, 1);
    endtask

    task automatic do_read(input logic [12:0] a);
        int lat, acks; logic [7:0] rd;
        access(1'b0, a, 8'h00, lat, rd, acks);
        chk(rd == exp_rd(a), "R3 read data", int'(rd), int'(exp_rd(a)));
        chk(lat == RD + 1, "R3 read latency", lat, RD + 1);
        chk(acks == 1, "R10 one ack per read", acks, 1);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_sel_n && !mem_sel && mem_oe_n && mem_we_n && !mem_dq_oe && !host_ack,
            "R1 standby after reset",
            {mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe, host_ack}, 6'b101100);
    endtask

    task automatic t_patterns;
        logic [7:0] pats [4] = '{8'h00, 8'hFF, 8'hAA, 8'h55};
        for (int i = 0; i < 4; i++) do_write(13'(16 + i), pats[i]);
        for (int i = 0; i < 4; i++) do_read(13'(16 + i));
        chk(mem_sel_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1 standby between accesses",
            {mem_sel_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
    endtask

    task automatic t_edges;
        do_write(13'h0000, 8'h3C);
        do_write(13'h1FFF, 8'hC3);
        do_read(13'h0000);
        do_read(13'h1FFF);
    endtask

    task automatic t_turnaround;
        // R6: read immediately after a write to the same word
        do_write(13'h0123, 8'h5A);
        do_read(13'h0123);
        do_write(13'h0124, 8'hA5);
        do_write(13'h0124, 8'h96);
        do_read(13'h0124);
    endtask

    task automatic t_input_change;
        // R8: host inputs altered after accept must not affect the access
        int lat = 0;
        do_write(13'h0200, 8'h11);
        host_req = 1'b1; host_wr = 1'b1; host_addr = 13'h0100; host_wdata = 8'h77;
        @(negedge clk);
        host_addr = 13'h0200; host_wdata = 8'h22; host_wr = 1'b0;
        do begin @(negedge clk); lat++; end while (!host_ack && lat < 50);
        host_req = 1'b0;
        @(negedge clk);
        expv[32'h0100] = 8'h77;
        chk(ram.exists(32'h0100) && ram[32'h0100] == 8'h77, "R8 latched data written",
            ram.exists(32'h0100) ? int'(ram[32'h0100]) : -1, 8'h77);
        do_read(13'h0200);
        do_read(13'h0100);
    endtask

    task automatic t_random;
        logic [15:0] lf = 16'hACE1;
        logic [12:0] adr [12];
        for (int i = 0; i < 12; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            adr[i] = lf[12:0];
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            do_write(adr[i], lf[7:0]);
        end
        for (int i = 0; i < 12; i++) do_read(adr[i]);
    endtask

    task automatic report;
        chk(e_pol == 0, "R2 select polarity", e_pol, 0);
        chk(e_cont == 0, "R6 bus contention", e_cont, 0);
        chk(e_turn == 0, "R6 driver released before OE", e_turn, 0);
        chk(e_addr == 0, "R7 address stable while selected", e_addr, 0);
        chk(e_oe_wr == 0, "R5 OE high in write", e_oe_wr, 0);
        chk(e_wz == 0, "R4 no drive during float time", e_wz, 0);
        chk(e_wp == 0, "R4 write pulse width", e_wp, 0);
        chk(e_dw == 0, "R4 data before strobe end", e_dw, 0);
        chk(e_hold == 0, "R9 hold and release", e_hold, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        t_reset;
        t_patterns;
        t_edges;
        t_turnaround;
        t_input_change;
        t_random;
        report;
    end
endmodule